// File: doc/BRIEF.md
# Serial Calendar Clock Slave

This block is the device side of a calendar clock that a host reaches through three pins: data in, a serial clock and a strobe. One line carries data back to the host. The host clocks a 4-bit command in with the strobe low and then pulses the strobe. The command selects what a 48-bit time register does. It can hold its contents, shift serially, take a snapshot of the running calendar, or load the calendar from the register.

Internally a packed-BCD calendar counter advances once per pulse of a one-second tick. It carries from seconds through minutes, hours, day of month, month and two-digit year. The weekday cycles from 1 to 7. Month length is respected, and February has 29 days when the year is a multiple of four. Every serial input is sampled on the system clock `clk_i`, and edges of the serial clock and strobe are detected in that domain.

The serial chain runs through the command stage into the time register. A host that shifts 48 data bits and then a 4-bit command leaves exactly those 48 bits in the register at the strobe.

Top module: `serial_calendar_clock`

## Requirements
- R1: After reset the calendar is 00:00:00, day 01, month 1, weekday 1, year 00. The mode is hold, the time register is all zero and `sdo_o` is 0.
- R2: Each rising edge of `sclk_i` seen while `stb_i` is low moves `sdi_i` into a 4-bit command stage, first bit ending in bit 0. A rising edge of `stb_i` applies the staged code: 0 hold, 1 shift, 2 set, 3 read. Codes 4 to 15 select hold.
- R3: In hold or read mode, `sclk_i` edges leave the time register unchanged. `sdo_o` shows register bit 0.
- R4: Applying code 3 copies the calendar into the register. Bits [7:0] hold seconds, [15:8] minutes, [23:16] hours, [31:24] day, [35:32] weekday, [39:36] month (binary 1–12) and [47:40] year. All fields are BCD except month and weekday.
- R5: In shift mode each qualifying `sclk_i` rise moves the register one place toward bit 0. Bit 47 takes the bit leaving command-stage bit 0. `sdo_o` presents the register's bit 0 before the edge, so a host reads bits 0 to 47 in order.
- R6: Applying code 2 copies the register into the calendar. The calendar then stays frozen until another mode is applied.
- R7: A tick advances the seconds in BCD. 59 seconds wraps to 00 and carries into minutes, 59 minutes carries into hours, and 23 hours wraps to 00 and carries into the day.
- R8: The day wraps to 01 after the month's last day: 30 in April, June, September and November, 28 in February, or 29 in February of a year divisible by 4, and 31 otherwise. The month then advances, and the weekday advances at every day change, wrapping 7 to 1.
- R9: After December the month returns to 1 and the year advances in BCD, wrapping 99 to 00.
- R10: Ticks are ignored while in set mode and counted again in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdi_i | input | 1 | Serial data from host |
| sclk_i | input | 1 | Serial clock from host |
| stb_i | input | 1 | Command strobe |
| tick_i | input | 1 | One-second advance pulse, one clk_i cycle wide |
| sdo_o | output | 1 | Serial data to host (register bit 0) |

## Verification
The bound checker watches every cycle for four things. It checks that a shift edge moves the register by exactly one place, and that the register stays still in the non-shift modes. It checks that the calendar stays frozen in set mode and that each accepted tick changes it. It also checks that the read and set strobes copy whole words between register and calendar. Only the bench's scenarios can show the rest. Those cover the calendar's field layout, the BCD and month-length rollovers across leap and non-leap Februaries and the century wrap, and that unknown codes behave as hold. They also cover a full write followed by a readback through the 52-bit chain.

// File: rtl/sercal_pkg.sv
package sercal_pkg;
  localparam int unsigned CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_HOLD  = 4'd0,
    CMD_SHIFT = 4'd1,
    CMD_SET   = 4'd2,
    CMD_READ  = 4'd3
  } cmd_e;

  typedef struct packed {
    logic [7:0] year;
    logic [3:0] mon;
    logic [3:0] wday;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  localparam int unsigned CAL_W = $bits(cal_t);

  localparam cal_t CAL_RST = '{year: 8'h00, mon: 4'd1, wday: 4'd1, day: 8'h01,
                               hour: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic cmd_e decode_cmd(logic [CMD_W-1:0] c);
    case (c)
      4'd1:    return CMD_SHIFT;
      4'd2:    return CMD_SET;
      4'd3:    return CMD_READ;
      default: return CMD_HOLD;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(logic [7:0] y);
    logic [7:0] yb;
    yb = 8'(y[7:4]) * 8'd10 + 8'(y[3:0]);
    return yb[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_day(logic [3:0] mon, logic [7:0] year);
    case (mon)
      4'd2:                     return is_leap(year) ? 8'h29 : 8'h28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 8'h30;
      default:                  return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/sercal_cmd.sv
module sercal_cmd
  import sercal_pkg::*;
#(
  parameter int unsigned W = CMD_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sdi_i,
  input  logic sclk_i,
  input  logic stb_i,
  output cmd_e mode_o,
  output logic tail_o,
  output logic shift_o,
  output logic stb_rise_o,
  output logic load_set_o,
  output logic load_read_o
);
  logic         sclk_q, stb_q;
  logic [W-1:0] cmd_q;
  cmd_e         mode_q;
  logic         sclk_rise, bit_en;

  assign sclk_rise  = sclk_i & ~sclk_q;
  assign stb_rise_o = stb_i & ~stb_q;
  assign bit_en     = sclk_rise & ~stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      stb_q  <= 1'b0;
      cmd_q  <= '0;
      mode_q <= CMD_HOLD;
    end else begin
      sclk_q <= sclk_i;
      stb_q  <= stb_i;
      if (bit_en)     cmd_q  <= {sdi_i, cmd_q[W-1:1]};
      if (stb_rise_o) mode_q <= decode_cmd(4'(cmd_q));
    end
  end

  assign mode_o      = mode_q;
  assign tail_o      = cmd_q[0];
  assign shift_o     = bit_en & (mode_q == CMD_SHIFT);
  assign load_set_o  = stb_rise_o & (decode_cmd(4'(cmd_q)) == CMD_SET);
  assign load_read_o = stb_rise_o & (decode_cmd(4'(cmd_q)) == CMD_READ);
endmodule

// File: rtl/sercal_shreg.sv
module sercal_shreg #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         sin_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= load_val_i;
    else if (shift_i) q <= {sin_i, q[W-1:1]};
  end

  assign q_o = q;
endmodule

// File: rtl/sercal_counter.sv
module sercal_counter
  import sercal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic [CAL_W-1:0] load_val_i,
  output logic [CAL_W-1:0] q_o
);
  cal_t q, nxt;

  always_comb begin
    nxt = q;
    if (q.sec != 8'h59) nxt.sec = bcd_inc(q.sec);
    else begin
      nxt.sec = 8'h00;
      if (q.min != 8'h59) nxt.min = bcd_inc(q.min);
      else begin
        nxt.min = 8'h00;
        if (q.hour != 8'h23) nxt.hour = bcd_inc(q.hour);
        else begin
          nxt.hour = 8'h00;
          nxt.wday = (q.wday >= 4'd7) ? 4'd1 : q.wday + 4'd1;
          if (q.day != last_day(q.mon, q.year)) nxt.day = bcd_inc(q.day);
          else begin
            nxt.day = 8'h01;
            if (q.mon < 4'd12) nxt.mon = q.mon + 4'd1;
            else begin
              nxt.mon  = 4'd1;
              nxt.year = (q.year == 8'h99) ? 8'h00 : bcd_inc(q.year);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= CAL_RST;
    else if (load_i)            q <= cal_t'(load_val_i);
    else if (tick_i && !hold_i) q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/serial_calendar_clock.sv
module serial_calendar_clock
  import sercal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sdi_i,
  input  logic sclk_i,
  input  logic stb_i,
  input  logic tick_i,
  output logic sdo_o
);
  cmd_e             mode;
  logic             tail, shift_en, stb_rise, load_set, load_read;
  logic [CAL_W-1:0] reg_q, cnt_q;

  sercal_cmd #(.W(CMD_W)) u_cmd (
    .clk_i, .rst_ni, .sdi_i, .sclk_i, .stb_i,
    .mode_o(mode), .tail_o(tail), .shift_o(shift_en), .stb_rise_o(stb_rise),
    .load_set_o(load_set), .load_read_o(load_read)
  );

  sercal_shreg #(.W(CAL_W)) u_reg (
    .clk_i, .rst_ni, .shift_i(shift_en), .sin_i(tail),
    .load_i(load_read), .load_val_i(cnt_q), .q_o(reg_q)
  );

  sercal_counter u_cnt (
    .clk_i, .rst_ni, .tick_i, .hold_i(mode == CMD_SET),
    .load_i(load_set), .load_val_i(reg_q), .q_o(cnt_q)
  );

  assign sdo_o = reg_q[0];
endmodule

// File: rtl/serial_calendar_clock_chk.sv
module serial_calendar_clock_chk
  import sercal_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             shift_en,
  input logic             stb_rise,
  input logic             load_set,
  input logic             load_read,
  input logic [CMD_W-1:0] mode,
  input logic [CAL_W-1:0] reg_q,
  input logic [CAL_W-1:0] cnt_q
);
  p_shift_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> reg_q[CAL_W-2:0] == $past(reg_q[CAL_W-1:1]));

  p_reg_still_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != CMD_SHIFT && !stb_rise) |=> $stable(reg_q));

  p_read_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_read |=> reg_q == $past(cnt_q));

  p_set_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_set |=> cnt_q == $past(reg_q));

  p_set_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CMD_SET && !load_set) |=> $stable(cnt_q));

  p_tick_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode != CMD_SET && !load_set) |=> cnt_q != $past(cnt_q));
endmodule

bind serial_calendar_clock serial_calendar_clock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .shift_en(shift_en),
  .stb_rise(stb_rise), .load_set(load_set), .load_read(load_read),
  .mode(mode), .reg_q(reg_q), .cnt_q(cnt_q)
);

// File: tb/serial_calendar_clock_test.sv
module serial_calendar_clock_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sdi = 1'b0, sclk = 1'b0, stb = 1'b0, tick = 1'b0;
  logic sdo;
  int   checks = 0, errors = 0;

  logic [47:0] exp_q[$];
  logic [47:0] obs_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  serial_calendar_clock uut (
    .clk_i(clk), .rst_ni(rst_ni), .sdi_i(sdi), .sclk_i(sclk),
    .stb_i(stb), .tick_i(tick), .sdo_o(sdo)
  );

  function automatic logic [47:0] mk(logic [7:0] y, logic [3:0] mo, logic [3:0] wd,
                                     logic [7:0] d, logic [7:0] h, logic [7:0] mi,
                                     logic [7:0] s);
    return {y, mo, wd, d, h, mi, s};
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sdo actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    sdi = b;
    @(posedge clk); #1 sclk = 1'b1;
    @(posedge clk); #1 sclk = 1'b0;
  endtask

  task automatic send_cmd(logic [3:0] c);
    for (int i = 0; i < 4; i++) send_bit(c[i]);
    @(posedge clk); #1 stb = 1'b1;
    @(posedge clk); #1 stb = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic expect_val(logic [47:0] v, string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic read_bits();
    logic [47:0] v;
    send_cmd(4'd1);
    for (int i = 0; i < 48; i++) begin
      v[i] = sdo;
      send_bit(1'b0);
    end
    obs_q.push_back(v);
  endtask

  task automatic read_time();
    send_cmd(4'd3);
    read_bits();
  endtask

  task automatic write_time(logic [47:0] v);
    send_cmd(4'd1);
    for (int i = 0; i < 48; i++) send_bit(v[i]);
    send_cmd(4'd2);
  endtask

  task automatic roll(logic [47:0] start, int n, logic [47:0] fin, string req);
    write_time(start);
    send_cmd(4'd0);
    ticks(n);
    expect_val(fin, req);
    read_time();
  endtask

  // scoreboard monitor
  initial forever begin
    logic [47:0] o, e;
    string t;
    wait (obs_q.size() != 0);
    o = obs_q.pop_front();
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (o !== e) begin
      errors++;
      $display("FAIL %s time actual %h expected %h", t, o, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] t_v;
    t_v = mk(8'h41, 4'd7, 4'd2, 8'h09, 8'h08, 8'h07, 8'h01);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk_bit("R1", sdo, 1'b0);
    expect_val(mk(8'h00, 4'd1, 4'd1, 8'h01, 8'h00, 8'h00, 8'h00), "R1");
    read_time();

    // R6 set, R10 ticks ignored while set
    write_time(t_v);
    ticks(3);
    send_cmd(4'd3);              // R4 snapshot
    send_cmd(4'd0);              // R2 hold
    chk_bit("R3", sdo, 1'b1);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    chk_bit("R3", sdo, 1'b1);
    send_cmd(4'd9);              // R2 unknown code acts as hold
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    chk_bit("R2", sdo, 1'b1);
    expect_val(t_v, "R6 R10 R3");
    read_bits();

    // R5 shift order: bit0 then bit1 on sdo
    send_cmd(4'd3);
    send_cmd(4'd1);
    chk_bit("R5", sdo, t_v[0]);
    send_bit(1'b0);
    chk_bit("R5", sdo, t_v[1]);
    send_bit(1'b0);
    chk_bit("R5", sdo, t_v[2]);

    // R7 seconds and minute/hour carries
    roll(mk(8'h05, 4'd6, 4'd4, 8'h15, 8'h12, 8'h34, 8'h09), 1,
         mk(8'h05, 4'd6, 4'd4, 8'h15, 8'h12, 8'h34, 8'h10), "R7");
    roll(mk(8'h05, 4'd6, 4'd4, 8'h15, 8'h12, 8'h59, 8'h59), 1,
         mk(8'h05, 4'd6, 4'd4, 8'h15, 8'h13, 8'h00, 8'h00), "R7");
    // R8 non-leap February, leap February, 30-day month
    roll(mk(8'h23, 4'd2, 4'd3, 8'h28, 8'h23, 8'h59, 8'h58), 2,
         mk(8'h23, 4'd3, 4'd4, 8'h01, 8'h00, 8'h00, 8'h00), "R8");
    roll(mk(8'h24, 4'd2, 4'd7, 8'h28, 8'h23, 8'h59, 8'h59), 1,
         mk(8'h24, 4'd2, 4'd1, 8'h29, 8'h00, 8'h00, 8'h00), "R8");
    roll(mk(8'h10, 4'd4, 4'd2, 8'h30, 8'h23, 8'h59, 8'h59), 1,
         mk(8'h10, 4'd5, 4'd3, 8'h01, 8'h00, 8'h00, 8'h00), "R8");
    // R9 year wrap
    roll(mk(8'h99, 4'd12, 4'd5, 8'h31, 8'h23, 8'h59, 8'h59), 1,
         mk(8'h00, 4'd1, 4'd6, 8'h01, 8'h00, 8'h00, 8'h00), "R9");

    wait (obs_q.size() == 0);
    @(posedge clk);
    summary();
    $finish;
  end
endmodule